// File: doc/BRIEF.md
# Multiplexed Local Bus Register Target

This block is the target side of a processor bus on which address and data share one 32-bit path. During the address phase the initiator pulses an address-latch strobe while a cycle-in-progress signal is held low; the block captures address bits 31:4 from the shared bus at that moment and takes word-address bits 3:2 from a separate two-bit input. The access direction is sampled with the address and holds for the whole transaction.

In the data phase every datum is answered by a one-cycle acknowledge pulse. Writes honour per-lane byte enables, reads drive the full word. Within a burst the low two word-address bits step after each acknowledged datum and wrap inside their four-word group, while the upper bits stay fixed. The initiator marks the final datum with a last-data flag. The block is backed by a parameterised register file of 16 words placed at an aligned base address; anything outside that window gets a bus-error pulse in place of the acknowledge, changes nothing and ends the transaction.

Top module: `mlb_target`

## Requirements
- R1: After reset, acknowledge and bus-error are high, the read-data enable is low and every register reads as zero.
- R2: Address bits 31:4 are captured from the shared bus on the clock edge where the latch strobe is high and cycle-in-progress is low; the word index is bits 5:4 of that capture concatenated above the separate low-address pins, and bits 3:0 of the shared bus are ignored during the address phase.
- R3: A write updates only lanes whose byte enable is low: enable 0 covers bits 7:0, 1 covers 15:8, 2 covers 23:16, 3 covers 31:24.
- R4: A read returns all 32 bits of the addressed register on the data output, with the read-data enable high in the acknowledge cycle.
- R5: Each datum is presented for one cycle in the data phase; the acknowledge (or bus-error) is low for exactly the next cycle, so one datum takes two cycles.
- R6: In a burst the low two word-address bits increment after each acknowledge, wrapping from 3 to 0, with the upper bits unchanged.
- R7: A datum presented with last-data low ends the transaction; no further response appears until a new latch strobe.
- R8: An address outside the window (bits 31:6 not equal to the base) gives a one-cycle bus-error pulse instead of acknowledge, leaves all registers unchanged and ends the transaction after that single datum.
- R9: If cycle-in-progress returns high during the data phase before a datum is answered, the block returns to idle with no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_ad_in | input | 32 | Shared address/data bus as driven by the initiator |
| bus_ad_out | output | 32 | Read data driven toward the shared bus |
| bus_ad_oe | output | 1 | High while read data is valid on bus_ad_out |
| lo_addr | input | 2 | Word-address bits 3:2 |
| ale | input | 1 | Address-latch strobe, active high |
| cip_n | input | 1 | Cycle in progress, active low |
| wr_n | input | 1 | Low for write, high for read |
| be_n | input | 4 | Per-lane byte enables, active low |
| last_n | input | 1 | Final datum marker, active low |
| ack_n | output | 1 | Datum acknowledge, active low |
| berr_n | output | 1 | Bus error, active low |

## Verification
The latch strobe is consumed on one edge, after which each datum presented in a cycle is answered exactly one cycle later: acknowledge, bus-error and read data all become visible right after the edge that samples the datum. The driver records, alongside each expected response, the cycle number it is due in; the monitor samples on the falling edge and compares both the due cycle and the contents, so an early, late or missing response fails. Responses that must not appear (after a last datum, after a bus error, after an abandoned cycle) are caught because the monitor treats any response with an empty queue as a failure, and the bench also compares response counts across those windows.

// File: rtl/mlb_pkg.sv
// Shared definitions for the multiplexed local bus target.
// Assumes a 32-bit shared address/data path.
package mlb_pkg;
    localparam int BUS_W  = 32;
    localparam int LANES  = BUS_W / 8;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_DATA = 2'd1,
        ST_RESP = 2'd2
    } mlb_state_t;
endpackage

// File: rtl/mlb_addr.sv
// Address capture and window decode.
// Holds address bits 31:4 from the latch phase and a low word counter that
// starts at the low-address pins and steps after each acknowledged datum.
// Assumes WORDS is a power of two of at least 8 and BASE_ADDR is aligned.
module mlb_addr #(
    parameter int          WORDS     = 16,
    parameter logic [31:0] BASE_ADDR = 32'h1000_0000,
    localparam int         IDX_W     = $clog2(WORDS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             capture,
    input  logic             adv,
    input  logic [31:4]      ad_hi,
    input  logic [1:0]       lo_in,
    output logic [IDX_W-1:0] idx,
    output logic             hit
);
    logic [31:4] upper_q;
    logic [1:0]  lo_q;

    // Capture the upper address and the starting low word bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            upper_q <= '0;
            lo_q    <= '0;
        end else if (capture) begin
            upper_q <= ad_hi;
            lo_q    <= lo_in;
        end else if (adv) begin
            lo_q    <= lo_q + 2'd1;
        end
    end

    // Word index and window match.
    always_comb begin
        idx = {upper_q[IDX_W+1:4], lo_q};
        hit = (upper_q[31:IDX_W+2] == BASE_ADDR[31:IDX_W+2]);
    end
endmodule

// File: rtl/mlb_regfile.sv
// Byte-lane writable register file with asynchronous read.
// Assumes one write per cycle; reset clears every word.
module mlb_regfile #(
    parameter int  WORDS = 16,
    localparam int IDX_W = $clog2(WORDS)
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            we,
    input  logic [IDX_W-1:0]                idx,
    input  logic [mlb_pkg::LANES-1:0]       be_n,
    input  logic [mlb_pkg::BUS_W-1:0]       wdata,
    output logic [mlb_pkg::BUS_W-1:0]       rdata
);
    logic [mlb_pkg::BUS_W-1:0] word_v [WORDS];

    for (genvar w = 0; w < WORDS; w++) begin : g_word
        logic [mlb_pkg::BUS_W-1:0] word_q;

        // Update the enabled lanes of this word on a write that selects it.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                word_q <= '0;
            end else if (we && (idx == IDX_W'(w))) begin
                for (int l = 0; l < mlb_pkg::LANES; l++) begin
                    if (!be_n[l]) word_q[l*8 +: 8] <= wdata[l*8 +: 8];
                end
            end
        end

        assign word_v[w] = word_q;
    end

    // Read the selected word.
    always_comb rdata = word_v[idx];
endmodule

// File: rtl/mlb_seq.sv
// Transaction sequencer: idle, data phase, response cycle.
// A datum sampled in the data phase is answered in the following cycle by a
// single acknowledge or bus-error pulse. Direction is held from the latch phase.
module mlb_seq (
    input  logic clk,
    input  logic rst_n,
    input  logic ale,
    input  logic cip_n,
    input  logic wr_n,
    input  logic last_n,
    input  logic hit,
    output logic capture,
    output logic we,
    output logic load_rd,
    output logic adv,
    output logic ack_n,
    output logic berr_n,
    output logic oe
);
    import mlb_pkg::*;

    mlb_state_t st_q, st_d;
    logic       rd_q;
    logic       last_q;
    logic       active;

    // Decode strobes for the datapath and the next state.
    always_comb begin
        capture = (st_q == ST_IDLE) && ale && !cip_n;
        active  = (st_q == ST_DATA) && !cip_n;
        we      = active && hit && !rd_q;
        load_rd = active && hit && rd_q;
        adv     = (st_q == ST_RESP) && !ack_n;
        st_d    = st_q;
        case (st_q)
            ST_IDLE: if (capture) st_d = ST_DATA;
            ST_DATA: st_d = cip_n ? ST_IDLE : ST_RESP;
            ST_RESP: st_d = (!berr_n || last_q || cip_n) ? ST_IDLE : ST_DATA;
            default: st_d = ST_IDLE;
        endcase
    end

    // State, direction, last flag and registered responses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            rd_q   <= 1'b0;
            last_q <= 1'b0;
            ack_n  <= 1'b1;
            berr_n <= 1'b1;
            oe     <= 1'b0;
        end else begin
            st_q   <= st_d;
            if (capture) rd_q   <= wr_n;
            if (active)  last_q <= !last_n;
            ack_n  <= !(active && hit);
            berr_n <= !(active && !hit);
            oe     <= load_rd;
        end
    end
endmodule

// File: rtl/mlb_target.sv
// Top of the multiplexed local bus register target.
// Ties address capture, sequencer and register file together and registers
// read data so it lines up with the acknowledge pulse.
module mlb_target #(
    parameter int          WORDS     = 16,
    parameter logic [31:0] BASE_ADDR = 32'h1000_0000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [31:0] bus_ad_in,
    output logic [31:0] bus_ad_out,
    output logic        bus_ad_oe,
    input  logic [1:0]  lo_addr,
    input  logic        ale,
    input  logic        cip_n,
    input  logic        wr_n,
    input  logic [3:0]  be_n,
    input  logic        last_n,
    output logic        ack_n,
    output logic        berr_n
);
    localparam int IDX_W = $clog2(WORDS);

    logic             capture, we, load_rd, adv, hit;
    logic [IDX_W-1:0] idx;
    logic [31:0]      rdata;

    mlb_addr #(.WORDS(WORDS), .BASE_ADDR(BASE_ADDR)) u_addr (
        .clk(clk), .rst_n(rst_n), .capture(capture), .adv(adv),
        .ad_hi(bus_ad_in[31:4]), .lo_in(lo_addr), .idx(idx), .hit(hit)
    );

    mlb_seq u_seq (
        .clk(clk), .rst_n(rst_n), .ale(ale), .cip_n(cip_n), .wr_n(wr_n),
        .last_n(last_n), .hit(hit), .capture(capture), .we(we),
        .load_rd(load_rd), .adv(adv), .ack_n(ack_n), .berr_n(berr_n),
        .oe(bus_ad_oe)
    );

    mlb_regfile #(.WORDS(WORDS)) u_rf (
        .clk(clk), .rst_n(rst_n), .we(we), .idx(idx), .be_n(be_n),
        .wdata(bus_ad_in), .rdata(rdata)
    );

    // Register read data for the response cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)       bus_ad_out <= '0;
        else if (load_rd) bus_ad_out <= rdata;
    end
endmodule

// File: rtl/mlb_target_chk.sv
// Protocol checker for mlb_target, attached by bind.
module mlb_target_chk (
    input logic clk,
    input logic rst_n,
    input logic cip_n,
    input logic ack_n,
    input logic berr_n,
    input logic bus_ad_oe
);
    // R1: reset drives the responses inactive
    p_reset_idle_r1: assert property (@(posedge clk)
        !rst_n |=> (ack_n && berr_n && !bus_ad_oe));

    // R5: acknowledge lasts a single cycle
    p_ack_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !ack_n |=> ack_n);

    // R5: a response follows a cycle with the transaction active
    p_resp_in_cycle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(ack_n) || $fell(berr_n)) |-> $past(!cip_n));

    // R8: bus error is a single-cycle pulse
    p_berr_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !berr_n |=> berr_n);

    // R8: never acknowledge and error together
    p_excl_resp_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(!ack_n && !berr_n));

    // R4: read data enable only with an acknowledge
    p_oe_with_ack_r4: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ad_oe |-> !ack_n);
endmodule

bind mlb_target mlb_target_chk u_chk (
    .clk(clk), .rst_n(rst_n), .cip_n(cip_n), .ack_n(ack_n),
    .berr_n(berr_n), .bus_ad_oe(bus_ad_oe)
);

// File: tb/mlb_target_test.sv
// Scoreboard bench: the driver queues expected responses with their due
// cycle, the monitor pops and compares them on the falling edge.
module mlb_target_test;
    localparam logic [31:0] BASE = 32'h1000_0000;

    typedef struct {
        bit          ok;
        bit          rd;
        logic [31:0] data;
        int          due;
        string       req;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] bus_ad_in = '0;
    logic [31:0] bus_ad_out;
    logic        bus_ad_oe;
    logic [1:0]  lo_addr = '0;
    logic        ale = 1'b0, cip_n = 1'b1, wr_n = 1'b1, last_n = 1'b1;
    logic [3:0]  be_n = 4'hF;
    logic        ack_n, berr_n;

    int          total = 0, fails = 0, cyc = 0, nresp = 0;
    exp_t        q[$];
    logic [31:0] shadow [16];
    logic [31:0] wdat [4];

    mlb_target uut (
        .clk(clk), .rst_n(rst_n), .bus_ad_in(bus_ad_in), .bus_ad_out(bus_ad_out),
        .bus_ad_oe(bus_ad_oe), .lo_addr(lo_addr), .ale(ale), .cip_n(cip_n),
        .wr_n(wr_n), .be_n(be_n), .last_n(last_n), .ack_n(ack_n), .berr_n(berr_n)
    );

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(bit cond, string req, string what, logic [31:0] act, logic [31:0] exp);
        total++;
        if (!cond) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Monitor: compare every response against the queue head.
    always @(negedge clk) begin
        if (rst_n && (!ack_n || !berr_n)) begin
            nresp++;
            if (q.size() == 0) begin
                check(0, "R7", "unexpected response", {30'b0, ack_n, berr_n}, 32'h3);
            end else begin
                exp_t e;
                e = q.pop_front();
                check(cyc == e.due, e.req, "response cycle", cyc, e.due);
                check(e.ok ? (!ack_n && berr_n) : (ack_n && !berr_n), e.req,
                      "response kind", {30'b0, ack_n, berr_n}, e.ok ? 32'h1 : 32'h2);
                if (e.ok && e.rd) begin
                    check(bus_ad_out == e.data, e.req, "read data", bus_ad_out, e.data);
                    check(bus_ad_oe === 1'b1, "R4", "read enable", {31'b0, bus_ad_oe}, 32'h1);
                end
            end
        end
    end

    // Driver: one transaction of n data; lo is the low-address pin value.
    task automatic access(logic [31:0] a, logic [1:0] lo, bit wr, int n,
                          logic [3:0] be, int linger, string req);
        bit ok;
        ok = (a[31:6] == BASE[31:6]);
        @(negedge clk);
        ale = 1'b1; cip_n = 1'b0; bus_ad_in = a; lo_addr = lo; wr_n = !wr;
        @(negedge clk);
        ale = 1'b0;
        for (int i = 0; i < n; i++) begin
            int   w;
            exp_t e;
            logic [31:0] m;
            w = {a[5:4], 2'(lo + 2'(i))};
            m = {{8{!be[3]}}, {8{!be[2]}}, {8{!be[1]}}, {8{!be[0]}}};
            if (ok && wr) shadow[w] = (shadow[w] & ~m) | (wdat[i] & m);
            e.ok = ok; e.rd = !wr; e.data = shadow[w]; e.due = cyc + 1; e.req = req;
            if (ok || i == 0) q.push_back(e);
            bus_ad_in = wr ? wdat[i] : 32'h0;
            be_n = be; last_n = (i == n - 1) ? 1'b0 : 1'b1;
            @(negedge clk);
            @(negedge clk);
        end
        last_n = 1'b1; be_n = 4'hF;
        repeat (linger) @(negedge clk);
        cip_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        #(5.0 * 100000);
        fails++; total++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        int n0;
        for (int i = 0; i < 16; i++) shadow[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state at the ports
        check(ack_n && berr_n && !bus_ad_oe, "R1", "reset outputs",
              {29'b0, ack_n, berr_n, bus_ad_oe}, 32'h6);
        // R1 R6: registers clear, burst read with wrap from word 2
        access(BASE, 2'd2, 0, 4, 4'h0, 0, "R6");
        // R2: shared-bus bits 3:0 ignored, low pins pick word 5
        wdat[0] = 32'h1122_3344;
        access(BASE + 32'h1C, 2'd1, 1, 1, 4'h0, 0, "R2");
        access(BASE + 32'h10, 2'd1, 0, 1, 4'h0, 0, "R2");
        // R3: lanes 0 and 2 only
        wdat[0] = 32'hAABB_CCDD;
        access(BASE + 32'h14, 2'd1, 1, 1, 4'b1010, 0, "R3");
        access(BASE + 32'h14, 2'd1, 0, 1, 4'h0, 0, "R3");
        // R6: burst write wrapping 9,10,11,8 then burst read 8..11
        wdat[0] = 32'h0000_0009; wdat[1] = 32'h0000_000A;
        wdat[2] = 32'h0000_000B; wdat[3] = 32'h0000_0008;
        access(BASE + 32'h20, 2'd1, 1, 4, 4'h0, 0, "R6");
        access(BASE + 32'h20, 2'd0, 0, 4, 4'h0, 0, "R4");
        // R7: last ends the burst, cycle held low afterwards
        n0 = nresp;
        access(BASE + 32'h30, 2'd0, 0, 2, 4'h0, 4, "R7");
        check(nresp - n0 == 2, "R7", "responses after last", nresp - n0, 2);
        // R8: out-of-window burst write aliasing word 0
        wdat[0] = 32'hDEAD_BEEF; wdat[1] = 32'hCAFE_F00D;
        n0 = nresp;
        access(BASE + 32'h40, 2'd0, 1, 2, 4'h0, 2, "R8");
        check(nresp - n0 == 1, "R8", "single error response", nresp - n0, 1);
        access(BASE, 2'd0, 0, 2, 4'h0, 0, "R8");
        // R9: abandon after the latch phase
        n0 = nresp;
        @(negedge clk);
        ale = 1'b1; cip_n = 1'b0; bus_ad_in = BASE; lo_addr = 2'd0; wr_n = 1'b0;
        @(negedge clk);
        ale = 1'b0; cip_n = 1'b1; bus_ad_in = 32'hFFFF_FFFF; be_n = 4'h0;
        repeat (4) @(negedge clk);
        be_n = 4'hF;
        check(nresp == n0, "R9", "no response on abort", nresp - n0, 0);
        access(BASE, 2'd0, 0, 1, 4'h0, 0, "R9");
        repeat (3) @(negedge clk);
        check(q.size() == 0, "R5", "all responses seen", q.size(), 0);
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule